// File: doc/BRIEF.md
# SPI Serial EEPROM Write Controller

This block is the device side of a small serial EEPROM, seen from its SPI pins. It samples the serial clock, chip select and data input with the system clock, puts the incoming bits together into bytes and decodes the first byte of each frame as a command. It supports four commands: write-enable, write-disable, status read and page write.

A page write first loads its data bytes into a page buffer. Programming does not start until chip select is released. An internal write cycle then runs for a programmable number of clocks. When it ends, the loaded bytes are copied into the memory array through a simple write port, and the write-enable latch clears itself.

Only the low twelve bits of the sixteen-bit address matter. Consecutive data bytes fill consecutive offsets inside one 32-byte page, and they wrap around at the end of that page.

Top module: `spi_eeprom_wr_ctrl`

## Requirements
- R1: After reset, status_busy and status_wel are 0, spi_so_en is 0 and mem_we stays low.
- R2: When the device is idle, command 0x06 sets the write-enable latch and command 0x04 clears it. Both commands are sent MSB first.
- R3: Command 0x05 returns a status byte MSB first, starting on the clock that follows the opcode. Bit 1 of the status byte is the write-enable latch, bit 0 is busy, and all other bits are 0. spi_so is driven only during that response.
- R4: A write command (0x02) sent while the write-enable latch is clear has no effect: no busy cycle follows and no array location is written.
- R5: A write carries sixteen address bits after the opcode. The top four bits are ignored, and the array address used is the low twelve bits.
- R6: Data bytes that follow the address are stored at consecutive byte offsets. The page bits (address bits 11..5) stay fixed for the whole sequence.
- R7: When the offset passes 31 it wraps to 0 in the same page. A later byte overwrites an earlier byte at the same offset, and each offset is written to the array at most once per cycle.
- R8: Nothing is programmed and busy stays 0 while chip select is low. Programming starts only when chip select rises.
- R9: Busy stays high for exactly WR_CYCLES + 32 clocks. The array writes happen only in the last 32 of those clocks, in ascending offset order. A status read during that time returns 0x03.
- R10: While busy, every command other than status read is ignored, including write-disable and a new write.
- R11: The write-enable latch is cleared when the write cycle ends.
- R12: A write frame is aborted if chip select rises before one whole data byte has arrived, or in the middle of a byte. An abort writes nothing, starts no busy cycle and leaves the write-enable latch as it was.
- R13: spi_so_en stays 0 for the whole of a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 or mode 3 |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data into the device |
| spi_so | output | 1 | Serial data out, high impedance when not driven |
| spi_so_en | output | 1 | High while spi_so is driven |
| mem_we | output | 1 | Array write strobe, one byte per clock |
| mem_addr | output | 12 | Array byte address |
| mem_wdata | output | 8 | Array write data |
| status_wel | output | 1 | Write-enable latch |
| status_busy | output | 1 | Internal write cycle in progress |

## Verification
A wrong frame mode or a wrong write-enable latch shows up at the ports within one frame. Either a busy cycle appears where none should, or one is missing, or a status read returns a byte that differs from the model. Offset or page errors stay hidden until the end of the write cycle. At that point each array write is compared with a model of the page, built from the order in which the bytes were loaded. The length of the busy window is counted clock by clock, so a wrong timer limit shows as a mismatch as soon as busy falls.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;

  typedef enum logic [2:0] {
    FM_IDLE,
    FM_OPC,
    FM_SKIP,
    FM_STAT,
    FM_ADDR,
    FM_DATA
  } frame_mode_t;

  // status byte layout: bit1 = write latch, bit0 = busy
  function automatic logic [7:0] status_byte(input logic wel, input logic busy);
    return {6'b0, wel, busy};
  endfunction

endpackage

// File: rtl/spi_ee_rx_front.sv
module spi_ee_rx_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       sel,
  output logic       frame_start,
  output logic       frame_end,
  output logic       sck_rise,
  output logic       sck_fall,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic [1:0] byte_num,
  output logic [2:0] bit_pos
);

  logic [1:0] sck_s, cs_s, si_s;
  logic       sck_q, cs_q;
  logic [6:0] sh_q;
  logic [1:0] num_q;
  logic [2:0] pos_q;

  function automatic logic [1:0] sat_inc(input logic [1:0] v);
    return (v == 2'd3) ? v : v + 2'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= 2'b00;
      cs_s  <= 2'b11;
      si_s  <= 2'b00;
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_s <= {sck_s[0], sck};
      cs_s  <= {cs_s[0], cs_n};
      si_s  <= {si_s[0], si};
      sck_q <= sck_s[1];
      cs_q  <= cs_s[1];
    end
  end

  assign sel         = !cs_s[1];
  assign frame_start = !cs_s[1] && cs_q;
  assign frame_end   = cs_s[1] && !cs_q;
  assign sck_rise    = sel && sck_s[1] && !sck_q;
  assign sck_fall    = sel && !sck_s[1] && sck_q;
  assign bit_pos     = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      pos_q     <= '0;
      num_q     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_num  <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (frame_start) begin
        pos_q <= '0;
        num_q <= '0;
      end else if (sck_rise) begin
        sh_q  <= {sh_q[5:0], si_s[1]};
        pos_q <= pos_q + 3'd1;
        if (pos_q == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {sh_q, si_s[1]};
          byte_num  <= num_q;
          num_q     <= sat_inc(num_q);
        end
      end
    end
  end

endmodule

// File: rtl/spi_ee_status_tx.sv
module spi_ee_status_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       arm,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic [7:0] status,
  output logic       so_bit,
  output logic       so_en
);

  logic       active_q, pend_q;
  logic [7:0] sh_q;
  logic [2:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      sh_q     <= '0;
      cnt_q    <= '0;
    end else if (!sel) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (arm) begin
      active_q <= 1'b1;
      pend_q   <= 1'b0;
      sh_q     <= status;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (sck_rise) begin
        pend_q <= 1'b1;
      end else if (sck_fall && pend_q) begin
        pend_q <= 1'b0;
        if (cnt_q == 3'd7) begin
          sh_q  <= status;
          cnt_q <= '0;
        end else begin
          sh_q  <= {sh_q[6:0], 1'b0};
          cnt_q <= cnt_q + 3'd1;
        end
      end
    end
  end

  assign so_bit = sh_q[7];
  assign so_en  = active_q && sel;

endmodule

// File: rtl/spi_ee_page_buf.sv
module spi_ee_page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [OFS_W-1:0] load_ofs,
  input  logic [7:0]       load_data,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [7:0]       rd_data,
  output logic             rd_valid
);

  logic [PAGE_BYTES-1:0][7:0] data_q;
  logic [PAGE_BYTES-1:0]      valid_q;
  logic [PAGE_BYTES-1:0]      slot_hit;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_hit
    assign slot_hit[g] = load && (load_ofs == OFS_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= '0;
    end else if (clear) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (slot_hit[i]) begin
          data_q[i]  <= load_data;
          valid_q[i] <= 1'b1;
        end
      end
    end
  end

  assign rd_data  = data_q[rd_ofs];
  assign rd_valid = valid_q[rd_ofs];

endmodule

// File: rtl/spi_ee_prog_timer.sv
module spi_ee_prog_timer #(
  parameter int WR_CYCLES  = 200,
  parameter int PAGE_BYTES = 32,
  parameter int OFS_W      = $clog2(PAGE_BYTES),
  parameter int CNT_W      = $clog2(WR_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             drain_en,
  output logic [OFS_W-1:0] drain_ofs,
  output logic             done
);

  typedef enum logic [1:0] {PT_IDLE, PT_WAIT, PT_DRAIN} phase_t;

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_CYCLES - 1);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(PAGE_BYTES - 1);

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PT_IDLE;
      cnt_q   <= '0;
      ofs_q   <= '0;
    end else begin
      unique case (phase_q)
        PT_IDLE: if (start) begin
          phase_q <= PT_WAIT;
          cnt_q   <= '0;
        end
        PT_WAIT: if (cnt_q == LAST_CNT) begin
          phase_q <= PT_DRAIN;
          ofs_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        PT_DRAIN: if (ofs_q == LAST_OFS) begin
          phase_q <= PT_IDLE;
        end else begin
          ofs_q <= ofs_q + 1'b1;
        end
        default: phase_q <= PT_IDLE;
      endcase
    end
  end

  assign busy      = (phase_q != PT_IDLE);
  assign drain_en  = (phase_q == PT_DRAIN);
  assign drain_ofs = ofs_q;
  assign done      = drain_en && (ofs_q == LAST_OFS);

  // R9: the drain phase starts only after the full wait
  a_r9_drain_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_en) |-> $past(phase_q == PT_WAIT));

endmodule

// File: rtl/spi_eeprom_wr_ctrl.sv
module spi_eeprom_wr_ctrl #(
  parameter int WR_CYCLES  = 200,
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sck,
  input  logic                 spi_cs_n,
  input  logic                 spi_si,
  output logic                 spi_so,
  output logic                 spi_so_en,
  output logic                 mem_we,
  output logic [ADDR_BITS-1:0] mem_addr,
  output logic [7:0]           mem_wdata,
  output logic                 status_wel,
  output logic                 status_busy
);
  import spi_ee_pkg::*;

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_BITS - OFS_W;
  localparam int HI_W  = ADDR_BITS - 8;

  logic             sel, frame_start, frame_end, sck_rise, sck_fall;
  logic             byte_vld;
  logic [7:0]       byte_data;
  logic [1:0]       byte_num;
  logic [2:0]       bit_pos;
  frame_mode_t      fmode_q;
  logic             wel_q, any_data_q;
  logic [HI_W-1:0]  addr_hi_q;
  logic [PG_W-1:0]  page_q;
  logic [OFS_W-1:0] slot_q;
  logic             busy, drain_en, prog_done;
  logic [OFS_W-1:0] drain_ofs;
  logic [7:0]       buf_rd_data;
  logic             buf_rd_valid;
  logic             so_bit;

  // named events
  logic opc_vld, write_accept, buf_load, prog_start, buf_clear, tx_arm, in_write_frame;
  logic [ADDR_BITS-1:0] full_addr;

  function automatic logic [OFS_W-1:0] next_slot(input logic [OFS_W-1:0] s);
    return s + 1'b1;
  endfunction

  spi_ee_rx_front u_front (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
    .sel(sel), .frame_start(frame_start), .frame_end(frame_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .byte_vld(byte_vld),
    .byte_data(byte_data), .byte_num(byte_num), .bit_pos(bit_pos)
  );

  assign opc_vld        = byte_vld && (byte_num == 2'd0) && (fmode_q == FM_OPC);
  assign write_accept   = opc_vld && !busy && (byte_data == OPC_WRITE) && wel_q;
  assign tx_arm         = opc_vld && (byte_data == OPC_RDSR);
  assign buf_load       = byte_vld && (byte_num == 2'd3) && (fmode_q == FM_DATA);
  assign prog_start     = frame_end && (fmode_q == FM_DATA) && any_data_q && (bit_pos == 3'd0);
  assign buf_clear      = write_accept || prog_done ||
                          (frame_end && (fmode_q == FM_DATA || fmode_q == FM_ADDR) && !prog_start);
  assign in_write_frame = (fmode_q == FM_ADDR) || (fmode_q == FM_DATA);
  assign full_addr      = {addr_hi_q, byte_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmode_q    <= FM_IDLE;
      wel_q      <= 1'b0;
      any_data_q <= 1'b0;
      addr_hi_q  <= '0;
      page_q     <= '0;
      slot_q     <= '0;
    end else begin
      if (frame_start) begin
        fmode_q    <= FM_OPC;
        any_data_q <= 1'b0;
      end else if (frame_end) begin
        fmode_q <= FM_IDLE;
      end else if (byte_vld) begin
        unique case (byte_num)
          2'd0: if (fmode_q == FM_OPC) begin
            if (busy) begin
              fmode_q <= (byte_data == OPC_RDSR) ? FM_STAT : FM_SKIP;
            end else begin
              unique case (byte_data)
                OPC_WREN: begin wel_q <= 1'b1; fmode_q <= FM_SKIP; end
                OPC_WRDI: begin wel_q <= 1'b0; fmode_q <= FM_SKIP; end
                OPC_RDSR: fmode_q <= FM_STAT;
                OPC_WRITE: fmode_q <= wel_q ? FM_ADDR : FM_SKIP;
                default: fmode_q <= FM_SKIP;
              endcase
            end
          end
          2'd1: if (fmode_q == FM_ADDR) addr_hi_q <= byte_data[HI_W-1:0];
          2'd2: if (fmode_q == FM_ADDR) begin
            page_q  <= full_addr[ADDR_BITS-1:OFS_W];
            slot_q  <= full_addr[OFS_W-1:0];
            fmode_q <= FM_DATA;
          end
          default: if (fmode_q == FM_DATA) begin
            slot_q     <= next_slot(slot_q);
            any_data_q <= 1'b1;
          end
        endcase
      end
      if (prog_done) wel_q <= 1'b0;
    end
  end

  spi_ee_page_buf #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear), .load(buf_load),
    .load_ofs(slot_q), .load_data(byte_data), .rd_ofs(drain_ofs),
    .rd_data(buf_rd_data), .rd_valid(buf_rd_valid)
  );

  spi_ee_prog_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy),
    .drain_en(drain_en), .drain_ofs(drain_ofs), .done(prog_done)
  );

  spi_ee_status_tx u_tx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .arm(tx_arm), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .status(status_byte(wel_q, busy)),
    .so_bit(so_bit), .so_en(spi_so_en)
  );

  assign spi_so      = spi_so_en ? so_bit : 1'bz;
  assign mem_we      = drain_en && buf_rd_valid;
  assign mem_addr    = {page_q, drain_ofs};
  assign mem_wdata   = buf_rd_data;
  assign status_wel  = wel_q;
  assign status_busy = busy;

  // R8: a busy cycle only begins right after chip select rises
  a_r8_start_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_busy) |-> $past(frame_end));
  // R9: array strobes only inside the busy window
  a_r9_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> status_busy);
  // R11: latch is clear once the cycle has ended
  a_r11_wel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_busy) |-> !status_wel);
  // R13: no output drive during a write frame
  a_r13_so_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_write_frame |-> !spi_so_en);
  // R4: data is loaded only with the latch set
  a_r4_load_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |-> wel_q);
  // R10: no loading while busy
  a_r10_busy_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    status_busy |-> !buf_load);

endmodule

// File: tb/spi_eeprom_wr_ctrl_tb.sv
module spi_eeprom_wr_ctrl_tb;

  localparam int WRC = 1500;
  localparam int H   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic        so, so_en, mem_we, wel, busy;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;

  int checks = 0, errors = 0;
  logic mode3 = 1'b0;
  logic [19:0] exp_q[$];
  int busy_cyc = 0, busy_rises = 0;
  logic busy_prev = 1'b0;
  logic in_wr = 1'b0;
  int so_in_wr = 0;

  always #4 clk = ~clk;

  spi_eeprom_wr_ctrl #(.WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_so(so), .spi_so_en(so_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .status_wel(wel), .status_busy(busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every array strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (busy && !busy_prev) busy_rises++;
      busy_prev = busy;
      if (in_wr && so_en) so_in_wr++;
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6 actual=%h expected=none", {mem_addr, mem_wdata});
        end else begin
          check("R6/R7 array write", {12'h0, mem_addr, mem_wdata}, {12'h0, exp_q.pop_front()});
        end
      end
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      if (mode3) sck = 1'b0;
      si = tx[i];
      clocks(H);
      rx[i] = so;
      sck = 1'b1;
      clocks(H);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx);
    logic [7:0] d;
    xfer_bits(tx, 8, d);
  endtask

  task automatic frame_open();
    sck = mode3;
    clocks(4);
    cs_n = 1'b0;
    clocks(6);
  endtask

  task automatic frame_close();
    clocks(6);
    cs_n = 1'b1;
    clocks(10);
  endtask

  task automatic cmd(input logic [7:0] opc);
    frame_open(); xfer(opc); frame_close();
  endtask

  task automatic read_status(input string req, input logic [7:0] exp);
    logic [7:0] rx;
    frame_open();
    xfer(8'h05);
    xfer_bits(8'h00, 8, rx);
    frame_close();
    check(req, {24'h0, rx}, {24'h0, exp});
  endtask

  task automatic reset_counts();
    busy_cyc = 0; busy_rises = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) clocks(1);
  endtask

  initial begin
    logic [7:0] d;
    clocks(5);
    rst_n = 1'b1;
    clocks(5);
    // R1 reset state
    check("R1 busy", {31'h0, busy}, 0);
    check("R1 wel", {31'h0, wel}, 0);
    check("R1 so_en", {31'h0, so_en}, 0);
    // R3 idle status
    read_status("R3 idle status", 8'h00);
    // R4 write without latch
    reset_counts();
    in_wr = 1'b1;
    frame_open(); xfer(8'h02); xfer(8'h00); xfer(8'h10); xfer(8'hAA); frame_close();
    in_wr = 1'b0;
    clocks(100);
    check("R4 no busy", busy_rises, 0);
    // R2 latch set/clear
    cmd(8'h06);
    read_status("R2 wren status", 8'h02);
    cmd(8'h04);
    read_status("R2 wrdi status", 8'h00);
    cmd(8'h06);
    // R5/R6 three bytes, upper address bits ignored
    reset_counts();
    in_wr = 1'b1;
    frame_open(); xfer(8'h02); xfer(8'hF1); xfer(8'hA3);
    xfer(8'h11); xfer(8'h22); xfer(8'h33);
    exp_q.push_back({12'h1A3, 8'h11});
    exp_q.push_back({12'h1A4, 8'h22});
    exp_q.push_back({12'h1A5, 8'h33});
    clocks(20);
    check("R8 no busy while cs low", {31'h0, busy}, 0);
    frame_close();
    in_wr = 1'b0;
    // R10 commands during busy
    cmd(8'h04);
    read_status("R9/R10 busy status keeps latch", 8'h03);
    frame_open(); xfer(8'h02); xfer(8'h00); xfer(8'h00); xfer(8'h55); frame_close();
    wait_idle();
    clocks(5);
    check("R9 busy length", busy_cyc, WRC + 32);
    check("R10 single busy cycle", busy_rises, 1);
    read_status("R11 latch cleared", 8'h00);
    check("R5 queue drained", exp_q.size(), 0);
    // R7 wrap in mode 3
    mode3 = 1'b1;
    read_status("R3 mode3 status", 8'h00);
    cmd(8'h06);
    read_status("R2 mode3 wren", 8'h02);
    in_wr = 1'b1;
    frame_open(); xfer(8'h02); xfer(8'h0F); xfer(8'hFE);
    xfer(8'hA1); xfer(8'hB2); xfer(8'hC3); xfer(8'hD4);
    exp_q.push_back({12'hFE0, 8'hC3});
    exp_q.push_back({12'hFE1, 8'hD4});
    exp_q.push_back({12'hFFE, 8'hA1});
    exp_q.push_back({12'hFFF, 8'hB2});
    frame_close();
    in_wr = 1'b0;
    clocks(5);
    wait_idle();
    clocks(5);
    check("R7 wrap drained", exp_q.size(), 0);
    // R7 overwrite after 34 bytes, mode 0
    mode3 = 1'b0;
    cmd(8'h06);
    in_wr = 1'b1;
    frame_open(); xfer(8'h02); xfer(8'h00); xfer(8'h40);
    for (int i = 0; i < 34; i++) xfer(8'h10 + 8'(i));
    for (int s = 0; s < 32; s++)
      exp_q.push_back({12'h040 + 12'(s), (s < 2) ? 8'h30 + 8'(s) : 8'h10 + 8'(s)});
    frame_close();
    in_wr = 1'b0;
    clocks(5);
    wait_idle();
    clocks(5);
    check("R7 overwrite drained", exp_q.size(), 0);
    check("R13 so quiet in write frames", so_in_wr, 0);
    // R12 aborts
    cmd(8'h06);
    reset_counts();
    frame_open(); xfer(8'h02); xfer(8'h00); xfer(8'h20); xfer(8'h77);
    xfer_bits(8'hFF, 3, d);
    frame_close();
    clocks(100);
    check("R12 mid-byte abort no busy", busy_rises, 0);
    read_status("R12 latch kept", 8'h02);
    frame_open(); xfer(8'h02); xfer(8'h00); xfer(8'h20); frame_close();
    clocks(100);
    check("R12 address-only abort no busy", busy_rises, 0);
    check("R12 no stray writes", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule